// File: doc/BRIEF.md
# Programmable Pixel Clock Divider

This block produces the pixel rate for a display controller from a reference clock. Software programs an 8-bit register whose low six bits hold a divider code F. When F is between 1 and 63 the block divides the reference clock by N = F + 1, so the ratio runs from 2 to 64. When F is 0 the counter is bypassed and the pixel rate equals the reference rate.

The block has two outputs, both in the reference clock domain. The first is a clock-enable pulse that downstream logic qualifies its flops with. The second is a divided level that can drive a pad or feed a glitch-free clock cell outside the block. Any write to the register restarts the count, so a new ratio always begins on a clean period boundary. The two upper register bits are reserved: they read as zero and have no effect on the division.

Top module: `pix_rate_divider`

## Requirements
- R1: While reset is held and after it is released, with no write yet, `rdData` is 0x00, `pixEn` is 1 and `pixLevel` is 0.
- R2: After a write, `rdData[5:0]` returns the written bits 5..0 and `rdData[7:6]` reads 0, even when ones were written to them.
- R3: With divider code 0 (bypass), `pixEn` is 1 in every cycle and `pixLevel` is 0 in every cycle.
- R4: With code F in 1..63, `pixEn` is 1 for exactly one cycle in every F+1 cycles. Counting the cycle after the write edge as cycle 0, the pulses fall in cycles F, 2F+1, and so on.
- R5: With code F in 1..63, `pixLevel` is 1 in the first floor((F+1)/2) cycles of each period (cycles 0 onward, measured from the write) and 0 in the remaining cycles of that period.
- R6: A write restarts the period from cycle 0, even when it writes the same code that is already loaded.
- R7: Code 63 gives a period of 64 cycles, with `pixLevel` high for 32 of them.
- R8: Bits 7..6 of the write data have no effect on the division. For example, writing 0xC2 divides by 3, exactly as writing 0x02 does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe, sampled on the rising edge of `clk` |
| wrData | input | 8 | Write data. Bits 5..0 hold the divider code; bits 7..6 are reserved |
| rdData | output | 8 | Register read-back. Bits 7..6 always read 0 |
| pixEn | output | 1 | Pixel clock-enable pulse |
| pixLevel | output | 1 | Divided clock level |

## Verification
The hardest case to reach from the ports is a write that lands in the middle of a running period. A correct restart and a missing restart look the same unless the write comes at a known, non-zero count. The stimulus therefore loads a code and lets it run a fixed number of cycles. It then writes the same code again and checks that the pulse and level pattern is aligned to the second write. It also switches directly between bypass and a divided ratio, so that the counter is shown to leave its held-at-zero state cleanly.

// File: rtl/pix_rate_divider_pkg.sv
package pix_rate_divider_pkg;
  localparam int REG_W       = 8;
  localparam int DIV_FIELD_W = 6;
  localparam int RSV_W       = REG_W - DIV_FIELD_W;
  localparam int HALF_W      = DIV_FIELD_W + 1;

  typedef struct packed {
    logic                   restart;
    logic                   bypass;
    logic [DIV_FIELD_W-1:0] lastCnt;
    logic [HALF_W-1:0]      highCnt;
  } divStrobes_t;
endpackage

// File: rtl/pix_rate_divider_ctrl.sv
module pix_rate_divider_ctrl
  import pix_rate_divider_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [DIV_FIELD_W-1:0] wrField,
  output logic [REG_W-1:0]       rdData,
  output divStrobes_t            strobes
);
  logic [DIV_FIELD_W-1:0] divField;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     divField <= '0;
    else if (wrEn) divField <= wrField;
  end

  assign rdData = {{RSV_W{1'b0}}, divField};

  always_comb begin
    strobes.restart = wrEn;
    strobes.bypass  = (divField == '0);
    strobes.lastCnt = divField;
    strobes.highCnt = ({1'b0, divField} + HALF_W'(1)) >> 1;
  end
endmodule

// File: rtl/pix_rate_divider_dp.sv
module pix_rate_divider_dp
  import pix_rate_divider_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  divStrobes_t strobes,
  output logic        pixEn,
  output logic        pixLevel
);
  logic [DIV_FIELD_W-1:0] cnt;
  logic                   atLast;

  assign atLast = (cnt == strobes.lastCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  cnt <= '0;
    else if (strobes.restart || strobes.bypass) cnt <= '0;
    else if (atLast)                            cnt <= '0;
    else                                        cnt <= cnt + 1'b1;
  end

  assign pixEn    = strobes.bypass | atLast;
  assign pixLevel = !strobes.bypass && ({1'b0, cnt} < strobes.highCnt);
endmodule

// File: rtl/pix_rate_divider.sv
module pix_rate_divider
  import pix_rate_divider_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             pixEn,
  output logic             pixLevel
);
  divStrobes_t strobes;
  logic        unusedRsv;

  assign unusedRsv = ^wrData[REG_W-1:DIV_FIELD_W];

  pix_rate_divider_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrField (wrData[DIV_FIELD_W-1:0]),
    .rdData  (rdData),
    .strobes (strobes)
  );

  pix_rate_divider_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .pixEn    (pixEn),
    .pixLevel (pixLevel)
  );
endmodule

// File: rtl/pix_rate_divider_chk.sv
module pix_rate_divider_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic       pixEn,
  input logic       pixLevel
);
  // R2
  readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> rdData == {2'b00, $past(wrData[5:0])});

  // R3
  bypass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[5:0] == 6'd0) |-> (pixEn && !pixLevel));

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[5:0] != 6'd0 && pixEn && !wrEn) |=> !pixEn);

  // R6
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[5:0] != 6'd0) |=> (pixLevel && !pixEn));

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> rdData[7:6] == 2'b00);
endmodule

bind pix_rate_divider pix_rate_divider_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrData   (wrData),
  .rdData   (rdData),
  .pixEn    (pixEn),
  .pixLevel (pixLevel)
);

// File: tb/pix_rate_divider_bench.sv
module pix_rate_divider_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       pixEn;
  logic       pixLevel;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pix_rate_divider u_pix_rate_divider (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .pixEn(pixEn), .pixLevel(pixLevel)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Returns at the negedge inside cycle 0, counted from the write edge.
  task automatic write_reg(logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    wrData = 8'h00;
  endtask

  // Checks the pulse and level pattern for ratio n over a number of cycles.
  task automatic check_pattern(string req, int n, int cycles);
    int bad = 0;
    for (int k = 0; k < cycles; k++) begin
      logic expEn  = ((k % n) == n - 1);
      logic expLvl = ((k % n) < (n / 2));
      if ((pixEn !== expEn || pixLevel !== expLvl) && bad == 0) begin
        bad = 1;
        $display("FAIL %s N=%0d cycle %0d actual en/lvl %b%b expected %b%b",
                 req, n, k, pixEn, pixLevel, expEn, expLvl);
      end
      if (k != cycles - 1) @(negedge clk);
    end
    checks++;
    if (bad != 0) errors++;
  endtask

  task automatic test_reset();
    @(negedge clk);
    check("R1 rdData in reset", rdData, 8'h00);
    check("R1 pixEn in reset", {7'd0, pixEn}, 8'h01);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 rdData after reset", rdData, 8'h00);
    check("R1 pixEn after reset", {7'd0, pixEn}, 8'h01);
    check("R1 pixLevel after reset", {7'd0, pixLevel}, 8'h00);
  endtask

  task automatic test_readback();
    write_reg(8'hFF);
    check("R2 reserved read zero", rdData, 8'h3F);
    write_reg(8'h15);
    check("R2 field readback", rdData, 8'h15);
  endtask

  task automatic test_ratios();
    write_reg(8'h01); check_pattern("R4 R5 N=2", 2, 12);
    write_reg(8'h02); check_pattern("R4 R5 N=3", 3, 15);
    write_reg(8'h05); check_pattern("R4 R5 N=6", 6, 24);
    write_reg(8'h06); check_pattern("R4 R5 N=7", 7, 28);
  endtask

  task automatic test_bypass();
    write_reg(8'h04);
    repeat (2) @(negedge clk);
    write_reg(8'h00); check_pattern("R3 bypass", 1, 10);
    write_reg(8'h03); check_pattern("R3 leave bypass N=4", 4, 16);
  endtask

  task automatic test_restart();
    write_reg(8'h07);
    repeat (3) @(negedge clk);
    write_reg(8'h07); check_pattern("R6 same-value restart", 8, 24);
  endtask

  task automatic test_max();
    write_reg(8'h3F); check_pattern("R7 N=64", 64, 192);
  endtask

  task automatic test_reserved();
    write_reg(8'hC2); check_pattern("R8 reserved bits ignored", 3, 15);
    check("R8 readback", rdData, 8'h02);
  endtask

  initial begin
    test_reset();
    test_readback();
    test_ratios();
    test_bypass();
    test_restart();
    test_max();
    test_reserved();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule